// File: doc/BRIEF.md
# Barrel Micro-Instruction Sequencer

This block lets one physical datapath controller serve 25 hardware contexts by strict time-slicing. A slot counter visits the contexts in a fixed ring, one per clock. In each slot the sequencer reads one 72-bit micro-word for the context that owns the slot, and issues it on the following cycle together with the context number and the micro-address it came from. Each context keeps a private micro-address register. Its progress therefore survives the 24 slots that belong to the others, and every context gets exactly one issue slot in 25, however busy the rest are. A context that is stopped or halted still uses up its slot, as an empty issue.

The last context (number 24) is the executive. Its start addresses land in the upper part of the 1536-word control store. The 24 port-control contexts start in the lower 1024 words. A host starts or stops a context through a single command port. The command waits in a per-context pending register and takes effect in that context's next slot. Every micro-word carries a two-bit next-address field that picks increment, jump or halt. The control store is a synchronous-read memory inside the block, and its write port is how its contents are loaded.

Top module: `barrel_useq`

## Requirements
- R1: `issue_ctx` steps through 0, 1, ..., 24 and back to 0, one step per clock, whatever the context states. It reads 24 during reset and in the first cycle after reset.
- R2: The slot of context c in cycle t is issued in cycle t+1. When `issue_valid` is 1, `issue_word` equals the control-store word at `issue_addr`.
- R3: A slot whose context is not running gives `issue_valid` = 0 and an all-zero `issue_word`.
- R4: A start command in cycle t takes effect at the first slot of that context after cycle t. The first word issued is the entry address: `cmd_addr` mod 1024 for contexts 0 to 23, and 1024 + (`cmd_addr` mod 512) for context 24.
- R5: The next-address field sits in bits [71:70]. The codes 00 and 11 make the next address of the context the issued address + 1, and 1535 wraps to 0.
- R6: Code 01 makes the next address of the context the target held in bits [69:59] of the issued word.
- R7: Code 10 issues its word and then halts the context. The context stays idle in every later slot until a new start command takes effect.
- R8: A stop command makes the context idle from its first slot after the command. If several commands arrive for one context before its slot, only the last one counts.
- R9: After reset every context is idle and `issue_valid` is 0.
- R10: A context's micro-address changes only in its own issue cycle or through its own commands. Activity in other contexts leaves it untouched.
- R11: A control-store write in cycle t is seen by reads in later cycles. A read of the same address in cycle t returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 11 | Control-store write address |
| cs_wdata | input | 72 | Control-store write data |
| cmd_valid | input | 1 | Host command present |
| cmd_start | input | 1 | 1 = start at entry, 0 = stop |
| cmd_ctx | input | 5 | Context addressed by the command |
| cmd_addr | input | 11 | Entry offset for a start command |
| issue_valid | output | 1 | Issued slot carries a live micro-word |
| issue_ctx | output | 5 | Context owning the issued slot |
| issue_addr | output | 11 | Micro-address of the issued word |
| issue_word | output | 72 | Issued micro-word (zero when idle) |

## Verification
A reference model in the bench runs alongside the design every cycle and compares the context number, the valid flag, the address and the word. The model is exercised first with directed sequences and then with random commands and store rewrites. The directed sequences are: the executive entry at the top of the store, which shows the region mapping and the wrap to 0; a jump into a halting word, which separates a jump from an increment and shows the halt persisting; and a stop followed by a start inside one rotation, which shows that the last pending command wins. The random phase keeps many contexts running at once with overlapping commands. A mismatch there exposes state leaking between contexts or a slot being skipped or taken twice.

// File: rtl/barrel_useq_pkg.sv
package barrel_useq_pkg;

  localparam int NCTX_DEF      = 25;
  localparam int DEPTH_DEF     = 1536;
  localparam int EXEC_BASE_DEF = 1024;
  localparam int DW_DEF        = 72;
  localparam int XW            = 16;  // wide address type used by the helpers

  typedef enum logic [1:0] {
    NX_INC  = 2'b00,
    NX_JUMP = 2'b01,
    NX_HALT = 2'b10,
    NX_RSV  = 2'b11
  } nx_e;

  // Sequential successor inside a store of the given depth.
  function automatic logic [XW-1:0] addr_step(input logic [XW-1:0] a, input int depth);
    if (int'(a) + 1 >= depth) return '0;
    return a + 16'd1;
  endfunction

  // Next micro-address of a context after it issued the word at address a.
  function automatic logic [XW-1:0] next_addr(input logic [XW-1:0] a, input logic [1:0] ctrl,
                                              input logic [XW-1:0] tgt, input int depth);
    case (nx_e'(ctrl))
      NX_JUMP: return tgt;
      NX_HALT: return a;
      default: return addr_step(a, depth);
    endcase
  endfunction

  // Entry address of a start command; the executive owns the upper region.
  function automatic logic [XW-1:0] entry_addr(input logic is_exec, input logic [XW-1:0] off,
                                               input int base, input int depth);
    if (is_exec) return XW'(base + int'(off) % (depth - base));
    return XW'(int'(off) % base);
  endfunction

endpackage

// File: rtl/barrel_useq_ring.sv
module barrel_useq_ring #(
  parameter int NCTX = 25,
  parameter int CTXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [CTXW-1:0] slot
);
  localparam logic [CTXW-1:0] LAST = CTXW'(NCTX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= (slot == LAST) ? '0 : slot + 1'b1;
  end
endmodule

// File: rtl/barrel_useq_store.sv
module barrel_useq_store #(
  parameter int DEPTH = 1536,
  parameter int AW    = 11,
  parameter int DW    = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) < DEPTH) mem_q[waddr] <= wdata;
  end

  // Registered read; an address past the store returns an all-zero word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= (int'(raddr) < DEPTH) ? mem_q[raddr] : '0;
  end
endmodule

// File: rtl/barrel_useq_ctx.sv
module barrel_useq_ctx
  import barrel_useq_pkg::*;
#(
  parameter int NCTX      = 25,
  parameter int CTXW      = 5,
  parameter int AW        = 11,
  parameter int DEPTH     = 1536,
  parameter int EXEC_BASE = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CTXW-1:0] slot,
  input  logic            cmd_valid,
  input  logic            cmd_start,
  input  logic [CTXW-1:0] cmd_ctx,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            upd_en,
  input  logic [CTXW-1:0] upd_ctx,
  input  logic            upd_halt,
  input  logic [AW-1:0]   upd_addr,
  output logic            rd_go,
  output logic [AW-1:0]   rd_addr
);
  localparam int EXEC_CTX = NCTX - 1;

  logic [NCTX-1:0] run_v, pend_v, pstart_v;
  logic [AW-1:0]   upc_a   [NCTX];
  logic [AW-1:0]   paddr_a [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    localparam logic IS_EXEC = (g == EXEC_CTX);
    logic          run_q, pend_q, pstart_q;
    logic [AW-1:0] upc_q, paddr_q;
    logic          my_slot, my_cmd, my_upd;
    logic [AW-1:0] entry;

    assign my_slot = (slot == CTXW'(g));
    assign my_cmd  = cmd_valid && (cmd_ctx == CTXW'(g));
    assign my_upd  = upd_en && (upd_ctx == CTXW'(g));
    assign entry   = AW'(entry_addr(IS_EXEC, XW'(cmd_addr), EXEC_BASE, DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q    <= 1'b0;
        pend_q   <= 1'b0;
        pstart_q <= 1'b0;
        upc_q    <= '0;
        paddr_q  <= '0;
      end else begin
        // A pending command is consumed in the context's own slot.
        if (my_slot && pend_q) begin
          pend_q <= 1'b0;
          run_q  <= pstart_q;
        end else if (my_upd && upd_halt) begin
          run_q  <= 1'b0;
        end
        if (my_upd && !upd_halt) upc_q <= upd_addr;
        // A new command overrides any older one still waiting.
        if (my_cmd) begin
          pend_q   <= 1'b1;
          pstart_q <= cmd_start;
          paddr_q  <= entry;
        end
      end
    end

    assign run_v[g]    = run_q;
    assign pend_v[g]   = pend_q;
    assign pstart_v[g] = pstart_q;
    assign upc_a[g]    = upc_q;
    assign paddr_a[g]  = paddr_q;
  end

  assign rd_go   = pend_v[slot] ? pstart_v[slot] : run_v[slot];
  assign rd_addr = pend_v[slot] ? paddr_a[slot]  : upc_a[slot];
endmodule

// File: rtl/barrel_useq.sv
module barrel_useq
  import barrel_useq_pkg::*;
#(
  parameter int  NCTX      = NCTX_DEF,
  parameter int  DEPTH     = DEPTH_DEF,
  parameter int  EXEC_BASE = EXEC_BASE_DEF,
  parameter int  DW        = DW_DEF,
  localparam int CTXW      = $clog2(NCTX),
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_we,
  input  logic [AW-1:0]   cs_waddr,
  input  logic [DW-1:0]   cs_wdata,
  input  logic            cmd_valid,
  input  logic            cmd_start,
  input  logic [CTXW-1:0] cmd_ctx,
  input  logic [AW-1:0]   cmd_addr,
  output logic            issue_valid,
  output logic [CTXW-1:0] issue_ctx,
  output logic [AW-1:0]   issue_addr,
  output logic [DW-1:0]   issue_word
);
  localparam int CTRL_HI = DW - 1;
  localparam int TGT_HI  = DW - 3;

  // Slot stage
  logic [CTXW-1:0] slot;
  logic            rd_go;
  logic [AW-1:0]   rd_addr;
  logic [DW-1:0]   rdata;

  // Issue stage
  logic            s1_valid_q;
  logic [CTXW-1:0] s1_ctx_q;
  logic [AW-1:0]   s1_addr_q;

  // Named issue-stage events
  logic [1:0]      nx_ctrl;
  logic [AW-1:0]   nx_tgt;
  logic            ev_halt;
  logic            ev_jump;
  logic [AW-1:0]   upd_addr;

  barrel_useq_ring #(.NCTX(NCTX), .CTXW(CTXW)) u_ring (
    .clk(clk), .rst_n(rst_n), .slot(slot)
  );

  barrel_useq_ctx #(
    .NCTX(NCTX), .CTXW(CTXW), .AW(AW), .DEPTH(DEPTH), .EXEC_BASE(EXEC_BASE)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .slot(slot),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_ctx(cmd_ctx), .cmd_addr(cmd_addr),
    .upd_en(s1_valid_q), .upd_ctx(s1_ctx_q), .upd_halt(ev_halt), .upd_addr(upd_addr),
    .rd_go(rd_go), .rd_addr(rd_addr)
  );

  barrel_useq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
    .raddr(rd_addr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_ctx_q   <= CTXW'(NCTX - 1);
      s1_addr_q  <= '0;
    end else begin
      s1_valid_q <= rd_go;
      s1_ctx_q   <= slot;
      s1_addr_q  <= rd_addr;
    end
  end

  assign nx_ctrl  = rdata[CTRL_HI -: 2];
  assign nx_tgt   = rdata[TGT_HI -: AW];
  assign ev_halt  = s1_valid_q && (nx_e'(nx_ctrl) == NX_HALT);
  assign ev_jump  = s1_valid_q && (nx_e'(nx_ctrl) == NX_JUMP);
  assign upd_addr = AW'(next_addr(XW'(s1_addr_q), nx_ctrl, XW'(nx_tgt), DEPTH));

  assign issue_valid = s1_valid_q;
  assign issue_ctx   = s1_ctx_q;
  assign issue_addr  = s1_addr_q;
  assign issue_word  = s1_valid_q ? rdata : '0;
endmodule

// File: rtl/barrel_useq_chk.sv
module barrel_useq_chk
  import barrel_useq_pkg::*;
#(
  parameter int NCTX  = 25,
  parameter int DEPTH = 1536,
  parameter int DW    = 72,
  parameter int CTXW  = 5,
  parameter int AW    = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [CTXW-1:0] cmd_ctx,
  input logic            issue_valid,
  input logic [CTXW-1:0] issue_ctx,
  input logic [AW-1:0]   issue_addr,
  input logic [DW-1:0]   issue_word
);
  // Per-context record of the previous issue, and whether a command may have intervened.
  logic [NCTX-1:0] last_ok, last_halt, touched;
  logic [AW-1:0]   last_next [NCTX];
  logic            cmd_q_v;
  logic [CTXW-1:0] cmd_q_ctx;

  logic [1:0]      w_ctrl;
  logic [AW-1:0]   w_next;
  logic            seq_chk, halt_chk;

  assign w_ctrl = issue_word[DW-1 -: 2];
  assign w_next = AW'(next_addr(XW'(issue_addr), w_ctrl, XW'(issue_word[DW-3 -: AW]), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ok   <= '0;
      last_halt <= '0;
      touched   <= '0;
      cmd_q_v   <= 1'b0;
      cmd_q_ctx <= '0;
      for (int i = 0; i < NCTX; i++) last_next[i] <= '0;
    end else begin
      cmd_q_v   <= cmd_valid;
      cmd_q_ctx <= cmd_ctx;
      for (int i = 0; i < NCTX; i++) begin
        if (issue_ctx == CTXW'(i)) begin
          last_ok[i]   <= issue_valid;
          last_halt[i] <= issue_valid && (nx_e'(w_ctrl) == NX_HALT);
          last_next[i] <= w_next;
          touched[i]   <= (cmd_valid && cmd_ctx == CTXW'(i)) ||
                          (cmd_q_v && cmd_q_ctx == CTXW'(i));
        end else if (cmd_valid && cmd_ctx == CTXW'(i)) begin
          touched[i] <= 1'b1;
        end
      end
    end
  end

  assign seq_chk  = issue_valid && last_ok[issue_ctx] && !last_halt[issue_ctx] && !touched[issue_ctx];
  assign halt_chk = last_ok[issue_ctx] && last_halt[issue_ctx] && !touched[issue_ctx];

  p_ring_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ctx == CTXW'(NCTX - 1) |=> issue_ctx == '0);

  p_ring_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ctx != CTXW'(NCTX - 1) |=> issue_ctx == $past(issue_ctx) + 1'b1);

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> issue_word == '0);

  // Covers the increment (R5) and jump (R6) paths and per-context isolation (R10).
  p_seq_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_chk |-> issue_addr == last_next[issue_ctx]);

  p_halt_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_chk |-> !issue_valid);
endmodule

bind barrel_useq barrel_useq_chk #(
  .NCTX(NCTX), .DEPTH(DEPTH), .DW(DW), .CTXW(CTXW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctx(cmd_ctx),
  .issue_valid(issue_valid), .issue_ctx(issue_ctx), .issue_addr(issue_addr),
  .issue_word(issue_word)
);

// File: tb/barrel_useq_tb.sv
module barrel_useq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 25, DEPTH = 1536, DW = 72, AW = 11, CW = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_we = 1'b0, cmd_valid = 1'b0, cmd_start = 1'b0;
  logic [AW-1:0] cs_waddr = '0, cmd_addr = '0;
  logic [DW-1:0] cs_wdata = '0;
  logic [CW-1:0] cmd_ctx = '0;
  logic          issue_valid;
  logic [CW-1:0] issue_ctx;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_word;

  always #(CLK_PERIOD / 2) clk = ~clk;

  barrel_useq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_ctx(cmd_ctx), .cmd_addr(cmd_addr),
    .issue_valid(issue_valid), .issue_ctx(issue_ctx), .issue_addr(issue_addr),
    .issue_word(issue_word)
  );

  int n_chk = 0, n_fail = 0;
  string phase = "";

  // Reference model
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_run [NCTX], m_pend [NCTX], m_pstart [NCTX];
  logic [AW-1:0] m_upc [NCTX], m_paddr [NCTX];
  string         m_why [NCTX];
  int            m_slot;
  bit            e_valid;
  int            e_ctx;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_word;
  string         e_why;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] f_entry(input int c, input logic [AW-1:0] off);
    if (c == NCTX - 1) return AW'(1024 + (int'(off) & 511));
    return AW'(int'(off) & 1023);
  endfunction

  function automatic logic [DW-1:0] mk_word(input logic [1:0] ctrl, input logic [AW-1:0] tgt);
    logic [63:0] p;
    p = {$urandom(), $urandom()};
    return {ctrl, tgt, p[58:0]};
  endfunction

  function automatic logic [DW-1:0] rand_word();
    int r;
    r = int'($urandom() % 32);
    if (r < 2)  return mk_word(2'b10, AW'($urandom() % DEPTH));
    if (r < 5)  return mk_word(2'b01, AW'($urandom() % DEPTH));
    if (r == 5) return mk_word(2'b11, AW'($urandom() % DEPTH));
    return mk_word(2'b00, AW'($urandom() % DEPTH));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCTX; i++) begin
      m_run[i] = 0; m_pend[i] = 0; m_pstart[i] = 0;
      m_upc[i] = '0; m_paddr[i] = '0; m_why[i] = "R9";
    end
    m_slot = 0; e_valid = 0; e_ctx = NCTX - 1; e_addr = '0; e_word = '0; e_why = "R9";
  endtask

  // One clock edge of the reference model, using the inputs held across the edge.
  task automatic model_edge();
    int c;
    bit go;
    logic [AW-1:0] a;
    if (e_valid) begin
      case (e_word[DW-1 -: 2])
        2'b01:   begin m_upc[e_ctx] = e_word[DW-3 -: AW]; m_why[e_ctx] = "R6"; end
        2'b10:   begin m_run[e_ctx] = 0; m_why[e_ctx] = "R7"; end
        default: begin
          m_upc[e_ctx] = (int'(e_addr) == DEPTH - 1) ? '0 : e_addr + 1'b1;
          m_why[e_ctx] = "R5";
        end
      endcase
    end
    c = m_slot;
    if (m_pend[c]) begin
      go = m_pstart[c]; a = m_paddr[c];
      m_run[c] = go; m_pend[c] = 0;
      m_why[c] = go ? "R4" : "R8";
    end else begin
      go = m_run[c]; a = m_upc[c];
    end
    e_valid = go; e_ctx = c; e_addr = a;
    e_word = go ? m_mem[a] : '0;
    e_why = m_why[c];
    if (cmd_valid) begin
      m_pend[cmd_ctx] = 1; m_pstart[cmd_ctx] = cmd_start;
      m_paddr[cmd_ctx] = f_entry(int'(cmd_ctx), cmd_addr);
    end
    if (cs_we) m_mem[cs_waddr] = cs_wdata;  // read happened first: old data
    m_slot = (m_slot == NCTX - 1) ? 0 : m_slot + 1;
  endtask

  task automatic compare();
    chk(issue_ctx == CW'(e_ctx), "R1", DW'(issue_ctx), DW'(e_ctx));
    chk(issue_valid == e_valid, e_why, DW'(issue_valid), DW'(e_valid));
    if (e_valid) begin
      chk(issue_addr == e_addr, e_why, DW'(issue_addr), DW'(e_addr));
      chk(issue_word == e_word, "R2 R11", issue_word, e_word);
    end else begin
      chk(issue_word == '0, "R3", issue_word, '0);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cs_we = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic run_to(input int c, input bit need_valid);
    for (int k = 0; k < 80; k++) begin
      cycle();
      if (issue_ctx == CW'(c) && (!need_valid || issue_valid)) break;
    end
  endtask

  task automatic cs_write(input int a, input logic [DW-1:0] w);
    cs_we = 1'b1; cs_waddr = AW'(a); cs_wdata = w;
    cycle();
  endtask

  task automatic send_cmd(input int c, input bit start, input int off);
    cmd_valid = 1'b1; cmd_ctx = CW'(c); cmd_start = start; cmd_addr = AW'(off);
  endtask

  initial begin
    logic [DW-1:0] w;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state visible in the first cycle
    chk(issue_valid == 1'b0, "R9", DW'(issue_valid), '0);
    chk(issue_ctx == CW'(NCTX - 1), "R1 R9", DW'(issue_ctx), DW'(NCTX - 1));
    repeat (NCTX) begin
      cycle();
      chk(issue_valid == 1'b0, "R9", DW'(issue_valid), '0);
    end

    // Load the whole control store through the write port (R11)
    for (int a = 0; a < DEPTH; a++) cs_write(a, rand_word());
    cs_write(1535, mk_word(2'b00, '0));
    cs_write(100, mk_word(2'b01, 11'd777));
    cs_write(777, mk_word(2'b10, '0));
    for (int a = 200; a < 204; a++) cs_write(a, mk_word(2'b00, '0));
    w = mk_word(2'b00, '0);
    cs_write(400, w);

    // Executive entry region and wrap at the top of the store
    phase = "exec";
    send_cmd(24, 1, 11'h7FF);
    run_to(24, 1);
    chk(issue_addr == 11'd1535, "R4", DW'(issue_addr), DW'(1535));
    run_to(24, 0);
    chk(issue_valid && issue_addr == '0, "R5", DW'(issue_addr), '0);

    // Port entry mapping, jump, then halt
    phase = "jump";
    send_cmd(3, 1, 1124);
    run_to(3, 1);
    chk(issue_addr == 11'd100, "R4", DW'(issue_addr), DW'(100));
    run_to(3, 0);
    chk(issue_valid && issue_addr == 11'd777, "R6", DW'(issue_addr), DW'(777));
    run_to(3, 0);
    chk(issue_valid == 1'b0, "R7", DW'(issue_valid), '0);
    chk(issue_word == '0, "R3", issue_word, '0);
    run_to(3, 0);
    chk(issue_valid == 1'b0, "R7", DW'(issue_valid), '0);

    // Stop, and last command wins
    phase = "stop";
    send_cmd(5, 1, 200);
    run_to(5, 1);
    chk(issue_addr == 11'd200, "R4", DW'(issue_addr), DW'(200));
    run_to(5, 0);
    chk(issue_valid && issue_addr == 11'd201, "R5", DW'(issue_addr), DW'(201));
    send_cmd(5, 0, 0);
    run_to(5, 0);
    chk(issue_valid == 1'b0, "R8", DW'(issue_valid), '0);
    send_cmd(5, 0, 0);
    cycle();
    send_cmd(5, 1, 300);
    run_to(5, 0);
    chk(issue_valid && issue_addr == 11'd300, "R8", DW'(issue_addr), DW'(300));

    // Word loaded through the write port is what gets issued
    phase = "load";
    send_cmd(7, 1, 400);
    run_to(7, 1);
    chk(issue_word == w, "R11", issue_word, w);

    // Random commands and store rewrites against the model
    phase = "R10";
    for (int n = 0; n < 5000; n++) begin
      int r;
      r = int'($urandom() % 16);
      if (r < 2) send_cmd(int'($urandom() % NCTX), ($urandom() % 5) != 0, int'($urandom() % 2048));
      if (r == 3) begin
        cs_we = 1'b1; cs_waddr = AW'($urandom() % DEPTH); cs_wdata = rand_word();
      end
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule